// File: doc/BRIEF.md
# Fixed-Index I2C Register Access Target

This block is an I2C target front end that gives an external bus host read and write access to a bank of 8-bit registers selected by a 6-bit index. It samples SCL and SDA through synchronising flops, finds START and STOP conditions and compares the incoming device address with its own. It keeps the register index from a write frame and moves data bytes between the bus and a plain register-file port that has one-cycle read and write strobes.

Within a frame the index never advances. Every data byte of a write burst lands in the same register. Every byte of a read burst is fetched again from the same register. The host can therefore stream into or drain a FIFO that sits behind one index, or poll one status register. A read frame uses whatever index the last index-setting write frame left behind. That index persists across frames, so the host resends it only when it wants a different register.

Top module: `i2c_fixreg_target`

## Requirements
- R1: After reset the SDA pull-down is released, both strobes are low and the held register index is 0.
- R2: The target acknowledges the first byte after a START only when its upper 7 bits equal the configured device address. On a mismatch it does not pull SDA low and raises no strobe for the rest of that frame, up to the next START.
- R3: In a write frame the byte after the address is the register index. Only its low 6 bits are kept and the top 2 bits are ignored. The target acknowledges this byte.
- R4: Each data byte after the index in a write frame is acknowledged and presented on the write-data port. All of these bytes go to the same held index.
- R5: In a read frame (R/W bit = 1, bit 0 of the address byte) every byte the target sends is the register-file value at the held index, transmitted MSB first.
- R6: A master acknowledge (SDA low in the ninth slot) on a read byte causes exactly one further fetch. A master NACK ends the frame with no further fetch.
- R7: The held index persists across STOP and new frames. It changes only when a write frame delivers a new index byte.
- R8: A repeated START restarts address decoding in any state, including after an address mismatch.
- R9: The target changes SDA only while SCL is low. It releases its acknowledge after the ninth falling edge of SCL.
- R10: The write strobe and the read strobe each last one system clock per byte, and they never occur together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_pull | output | 1 | Drives SDA low when 1 (open drain) |
| reg_idx | output | IDX_W | Held register index |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | DATA_W | Byte to write, valid with reg_wr |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | DATA_W | Register-file value at reg_idx, sampled while reg_rd is high |

## Verification
The bench writes and reads back every non-FIFO index while varying the top two bits of the index byte. An engine that auto-incremented, or that kept the upper index bits, would land data in a neighbouring register and read back the wrong byte. A counting FIFO behind the highest index shows whether each acknowledged read byte pops exactly once and a NACKed byte does not pop. An extra or missing strobe would skip or repeat FIFO values. Address mismatches with the following bytes sent anyway catch a design that wakes up on mid-frame bytes. A repeated START issued straight after a mismatch catches one that waits for STOP before decoding again. Read frames sent without a preceding index frame expose a design that clears its index at STOP.

// File: rtl/i2c_fixreg_pkg.sv
package i2c_fixreg_pkg;
   typedef enum logic [2:0] {
      FR_IDLE,
      FR_ADDR,
      FR_IDX,
      FR_WDATA,
      FR_RDATA,
      FR_SKIP
   } fr_state_t;

   localparam int unsigned BYTE_BITS = 8;
   localparam logic [3:0]  ACK_SLOT  = 4'd8;
   localparam logic [3:0]  ACK_DONE  = 4'd9;
endpackage

// File: rtl/i2c_fixreg_sync.sv
module i2c_fixreg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_q;
   logic              sda_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff[0] <= 1'b1;
               sda_ff[0] <= 1'b1;
            end else begin
               scl_ff[0] <= scl_raw;
               sda_ff[0] <= sda_raw;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff[g] <= 1'b1;
               sda_ff[g] <= 1'b1;
            end else begin
               scl_ff[g] <= scl_ff[g-1];
               sda_ff[g] <= sda_ff[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_ff[STAGES-1];
         sda_q <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_fixreg_idx.sv
module i2c_fixreg_idx #(
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] din,
   output logic [IDX_W-1:0] idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx <= '0;
      else if (load) idx <= din;
   end
endmodule

// File: rtl/i2c_fixreg_engine.sv
module i2c_fixreg_engine
   import i2c_fixreg_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h2A,
   parameter int unsigned IDX_W    = 6,
   parameter int unsigned DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   output logic              idx_load,
   output logic [IDX_W-1:0]  idx_val,
   input  logic [DATA_W-1:0] rdata,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wdata,
   output logic              rd_stb,
   output logic              sda_pull
);
   localparam int unsigned MSB = DATA_W - 1;

   fr_state_t         state;
   logic [3:0]        bitcnt;
   logic [DATA_W-1:0] shreg;
   logic              own_ack;
   logic              active;

   assign active  = (state != FR_IDLE) && (state != FR_SKIP);
   assign idx_val = shreg[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= FR_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         own_ack  <= 1'b0;
         sda_pull <= 1'b0;
         wr_stb   <= 1'b0;
         rd_stb   <= 1'b0;
         idx_load <= 1'b0;
         wdata    <= '0;
      end else begin
         wr_stb   <= 1'b0;
         rd_stb   <= 1'b0;
         idx_load <= 1'b0;
         if (rd_stb) shreg <= rdata;
         if (start_det) begin
            state    <= FR_ADDR;
            bitcnt   <= '0;
            own_ack  <= 1'b0;
            sda_pull <= 1'b0;
         end else if (stop_det) begin
            state    <= FR_IDLE;
            bitcnt   <= '0;
            own_ack  <= 1'b0;
            sda_pull <= 1'b0;
         end else if (active) begin
            if (scl_rise) begin
               if (bitcnt == ACK_SLOT) begin
                  bitcnt <= ACK_DONE;
                  if (state == FR_RDATA) begin
                     if (own_ack || !sda_s) rd_stb <= 1'b1;
                     else                   state  <= FR_SKIP;
                  end
               end else if (bitcnt < ACK_SLOT) begin
                  bitcnt <= bitcnt + 4'd1;
                  if (state != FR_RDATA) shreg <= {shreg[MSB-1:0], sda_s};
               end
            end else if (scl_fall) begin
               if (bitcnt == ACK_SLOT) begin
                  case (state)
                     FR_ADDR: begin
                        if (shreg[MSB:1] == DEV_ADDR) begin
                           sda_pull <= 1'b1;
                           own_ack  <= 1'b1;
                           state    <= shreg[0] ? FR_RDATA : FR_IDX;
                        end else begin
                           state <= FR_SKIP;
                        end
                     end
                     FR_IDX: begin
                        idx_load <= 1'b1;
                        sda_pull <= 1'b1;
                        own_ack  <= 1'b1;
                        state    <= FR_WDATA;
                     end
                     FR_WDATA: begin
                        wr_stb   <= 1'b1;
                        wdata    <= shreg;
                        sda_pull <= 1'b1;
                        own_ack  <= 1'b1;
                     end
                     default: sda_pull <= 1'b0;
                  endcase
               end else if (bitcnt == ACK_DONE) begin
                  bitcnt   <= '0;
                  own_ack  <= 1'b0;
                  sda_pull <= (state == FR_RDATA) ? ~shreg[MSB] : 1'b0;
               end else if (state == FR_RDATA && bitcnt != 4'd0) begin
                  shreg    <= {shreg[MSB-1:0], 1'b0};
                  sda_pull <= ~shreg[MSB-1];
               end
            end
         end
      end
   end
endmodule

// File: rtl/i2c_fixreg_target.sv
module i2c_fixreg_target #(
   parameter logic [6:0]  DEV_ADDR    = 7'h2A,
   parameter int unsigned IDX_W       = 6,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_pull,
   output logic [IDX_W-1:0]  reg_idx,
   output logic              reg_wr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_rd,
   input  logic [DATA_W-1:0] reg_rdata
);
   if (DATA_W != i2c_fixreg_pkg::BYTE_BITS) begin : g_bad_data_w
      $error("DATA_W must equal the bus byte width of 8");
   end
   if (IDX_W < 1 || IDX_W > DATA_W) begin : g_bad_idx_w
      $error("IDX_W must lie between 1 and DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             scl_s;
   logic             sda_s;
   logic             scl_rise;
   logic             scl_fall;
   logic             start_det;
   logic             stop_det;
   logic             idx_load;
   logic [IDX_W-1:0] idx_val;

   i2c_fixreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_raw   (scl_in),
      .sda_raw   (sda_in),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_fixreg_engine #(
      .DEV_ADDR (DEV_ADDR),
      .IDX_W    (IDX_W),
      .DATA_W   (DATA_W)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .idx_load  (idx_load),
      .idx_val   (idx_val),
      .rdata     (reg_rdata),
      .wr_stb    (reg_wr),
      .wdata     (reg_wdata),
      .rd_stb    (reg_rd),
      .sda_pull  (sda_pull)
   );

   i2c_fixreg_idx #(.IDX_W(IDX_W)) u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (idx_load),
      .din   (idx_val),
      .idx   (reg_idx)
   );
endmodule

// File: rtl/i2c_fixreg_target_chk.sv
module i2c_fixreg_target_chk #(
   parameter int unsigned IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             sda_pull,
   input logic             reg_wr,
   input logic             reg_rd,
   input logic [IDX_W-1:0] reg_idx
);
   // R10
   wr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   // R10
   rd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);

   // R10
   no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));

   // R9
   pull_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_s);

   // R9
   release_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sda_pull) && !$past(scl_s)) |-> !scl_s);

   // R7
   idx_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_idx) |-> !scl_s);
endmodule

bind i2c_fixreg_target i2c_fixreg_target_chk #(.IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .sda_pull (sda_pull),
   .reg_wr   (reg_wr),
   .reg_rd   (reg_rd),
   .reg_idx  (reg_idx)
);

// File: tb/i2c_fixreg_target_bench.sv
`timescale 1ns/1ps
module i2c_fixreg_target_bench;
   localparam logic [6:0] ADDR = 7'h2A;
   localparam int H = 10;
   localparam int FIFO_IDX = 63;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_pull;
   logic [5:0] reg_idx;
   logic       reg_wr;
   logic [7:0] reg_wdata;
   logic       reg_rd;
   logic [7:0] reg_rdata;
   logic       sda_line;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic [7:0] mem [64];
   logic [7:0] fifo_cnt;
   int         wr_cnt;
   int         rd_cnt;

   always #10 clk = ~clk;

   assign sda_line = sda_m & ~sda_pull;

   i2c_fixreg_target u_i2c_fixreg_target (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_m),
      .sda_in    (sda_line),
      .sda_pull  (sda_pull),
      .reg_idx   (reg_idx),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata)
   );

   always_comb reg_rdata = (reg_idx == 6'(FIFO_IDX)) ? fifo_cnt : mem[reg_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
         fifo_cnt <= 8'h00;
         wr_cnt   <= 0;
         rd_cnt   <= 0;
      end else begin
         if (reg_wr) begin
            mem[reg_idx] <= reg_wdata;
            wr_cnt       <= wr_cnt + 1;
         end
         if (reg_rd) begin
            rd_cnt <= rd_cnt + 1;
            if (reg_idx == 6'(FIFO_IDX)) fifo_cnt <= fifo_cnt + 8'd1;
         end
      end
   end

   task automatic summary_and_end();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 190000) begin
         fails++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
         summary_and_end();
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_h(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_h(H);
      scl_m = 1'b1; wait_h(H);
      sda_m = 1'b0; wait_h(H);
      scl_m = 1'b0; wait_h(H);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_h(H);
      scl_m = 1'b1; wait_h(H);
      sda_m = 1'b1; wait_h(H);
   endtask

   task automatic put_byte(input logic [7:0] b, output logic ack, output logic held);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wait_h(H);
         scl_m = 1'b1; wait_h(H);
         scl_m = 1'b0;
      end
      sda_m = 1'b1; wait_h(H);
      scl_m = 1'b1; wait_h(H / 2);
      ack = sda_line; wait_h(H / 2);
      scl_m = 1'b0; wait_h(6);
      held = sda_pull;
      wait_h(H - 6);
   endtask

   task automatic get_byte(input logic nack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wait_h(H);
         scl_m = 1'b1; wait_h(H / 2);
         b[i] = sda_line; wait_h(H / 2);
         scl_m = 1'b0;
      end
      sda_m = nack; wait_h(H);
      scl_m = 1'b1; wait_h(H);
      scl_m = 1'b0;
      sda_m = 1'b1;
   endtask

   task automatic set_index(input logic [7:0] ib);
      logic a, h;
      bus_start();
      put_byte({ADDR, 1'b0}, a, h);
      put_byte(ib, a, h);
      check(a == 1'b0, "R3 index byte ack", int'(a), 0);
      bus_stop();
   endtask

   initial begin
      logic       a, h;
      logic [7:0] d;
      logic [7:0] base;
      int         w0, r0;

      wait_h(5);
      check(sda_pull == 1'b0, "R1 sda_pull after reset", int'(sda_pull), 0);
      check(reg_wr == 1'b0 && reg_rd == 1'b0, "R1 strobes after reset", int'({reg_wr, reg_rd}), 0);
      check(reg_idx == 6'd0, "R1 index after reset", int'(reg_idx), 0);
      rst_n = 1'b1;
      wait_h(5);

      // Sweep every plain index; upper two index bits vary and must be ignored (R3, R4, R5)
      for (int i = 0; i < FIFO_IDX; i++) begin
         logic [7:0] v;
         v = 8'((i * 37 + 11) & 8'hFF);
         bus_start();
         put_byte({ADDR, 1'b0}, a, h);
         check(a == 1'b0, "R2 address ack", int'(a), 0);
         put_byte({2'(i), 6'(i)}, a, h);
         check(a == 1'b0, "R3 index ack", int'(a), 0);
         put_byte(v, a, h);
         check(a == 1'b0, "R4 data ack", int'(a), 0);
         bus_stop();
         check(mem[i] == v, "R4 write landed", int'(mem[i]), int'(v));
         check(reg_idx == 6'(i), "R3 index low bits", int'(reg_idx), i);
         bus_start();
         put_byte({ADDR, 1'b1}, a, h);
         check(a == 1'b0, "R2 read address ack", int'(a), 0);
         get_byte(1'b1, d);
         check(d == v, "R5 read back", int'(d), int'(v));
         bus_stop();
      end

      // Burst of three bytes to index 10: no auto-increment (R4, R10, R9)
      w0 = wr_cnt;
      bus_start();
      put_byte({ADDR, 1'b0}, a, h);
      put_byte(8'd10, a, h);
      put_byte(8'h11, a, h);
      put_byte(8'h22, a, h);
      put_byte(8'h33, a, h);
      check(h == 1'b0, "R9 ack released after ninth fall", int'(h), 0);
      bus_stop();
      check(wr_cnt - w0 == 3, "R10 one write strobe per byte", wr_cnt - w0, 3);
      check(mem[10] == 8'h33, "R4 burst lands on one index", int'(mem[10]), 8'h33);
      check(mem[11] == 8'((11 * 37 + 11) & 8'hFF), "R4 neighbour untouched",
            int'(mem[11]), (11 * 37 + 11) & 8'hFF);

      // Read frames with no index frame reuse index 10 (R7, R5, R6)
      r0 = rd_cnt;
      bus_start();
      put_byte({ADDR, 1'b1}, a, h);
      get_byte(1'b0, d); check(d == 8'h33, "R7 persisted index byte0", int'(d), 8'h33);
      get_byte(1'b0, d); check(d == 8'h33, "R5 same index byte1", int'(d), 8'h33);
      get_byte(1'b1, d); check(d == 8'h33, "R5 same index byte2", int'(d), 8'h33);
      bus_stop();
      check(rd_cnt - r0 == 3, "R6 fetch count with final NACK", rd_cnt - r0, 3);

      // FIFO draining at the top index (R6)
      set_index(8'(FIFO_IDX));
      base = fifo_cnt;
      r0 = rd_cnt;
      bus_start();
      put_byte({ADDR, 1'b1}, a, h);
      for (int k = 0; k < 4; k++) begin
         get_byte(k == 3, d);
         check(d == 8'(base + 8'(k)), "R6 fifo sequence", int'(d), int'(base) + k);
      end
      bus_stop();
      check(rd_cnt - r0 == 4, "R6 fifo pops", rd_cnt - r0, 4);

      // Address mismatches: no ack, no strobe (R2)
      for (int m = 0; m < 4; m++) begin
         logic [6:0] bad;
         bad = ADDR ^ (7'h01 << (m * 2));
         w0 = wr_cnt;
         r0 = rd_cnt;
         bus_start();
         put_byte({bad, 1'b0}, a, h);
         check(a == 1'b1, "R2 no ack on mismatch", int'(a), 1);
         put_byte(8'h05, a, h);
         check(a == 1'b1, "R2 ignored after mismatch", int'(a), 1);
         put_byte(8'h99, a, h);
         bus_stop();
         check(wr_cnt == w0 && rd_cnt == r0, "R2 no strobes on mismatch", wr_cnt - w0, 0);
         check(reg_idx == 6'(FIFO_IDX), "R7 index kept over foreign frame", int'(reg_idx), FIFO_IDX);
      end

      // Repeated START: index then read in one transaction (R8)
      bus_start();
      put_byte({ADDR, 1'b0}, a, h);
      put_byte(8'd20, a, h);
      bus_start();
      put_byte({ADDR, 1'b1}, a, h);
      check(a == 1'b0, "R8 ack after repeated start", int'(a), 0);
      get_byte(1'b1, d);
      bus_stop();
      check(d == 8'((20 * 37 + 11) & 8'hFF), "R8 read after repeated start",
            int'(d), (20 * 37 + 11) & 8'hFF);

      // Repeated START right after a mismatch (R8)
      bus_start();
      put_byte({ADDR ^ 7'h40, 1'b0}, a, h);
      bus_start();
      put_byte({ADDR, 1'b0}, a, h);
      check(a == 1'b0, "R8 decode resumes after mismatch", int'(a), 0);
      put_byte(8'd21, a, h);
      put_byte(8'h5A, a, h);
      bus_stop();
      check(mem[21] == 8'h5A, "R8 write after mismatch restart", int'(mem[21]), 8'h5A);

      wait_h(20);
      summary_and_end();
   end
endmodule